// File: doc/BRIEF.md
# Multi-level priority bus arbiter

This block decides which of eight local devices may drive a shared bus, while taking into account the request levels that peer arbiters broadcast. Each device raises a 2-bit active-low request code that asks for either high or low urgency. Each device also has a 9-bit programmed priority. The two combine into a ranking key. The best local requester is then held against every active peer level, and a grant goes out only when the local side wins.

Configuration is loaded bit-serially before the arbiter runs. A shift port selects either the 72-bit priority register or the 4-bit arbiter number. Start-up has two steps. The asynchronous main reset is released first, and a synchronous arbiter stop input is released later. A granted device keeps the bus until it withdraws its request. Each new grant is marked by a one-cycle active-low start strobe. The busy output is intended to be looped back into the busy input.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While rst_ni is low, grant_o is 0, start_no is 1 and busy_o is 0. The priority register, the arbiter number and the round-robin pointer reset to 0, 0 and device 7.
- R2: While arb_stop_i is high, no grant is issued. A grant that is held is cleared at the first clock edge at which arb_stop_i is high.
- R3: On each edge with cfg_shift_i high, cfg_din_i enters the MSB of the register selected by cfg_sel_i, and the register shifts one place toward the LSB. cfg_sel_i=0 selects the 72-bit priority register, cfg_sel_i=1 selects the 4-bit arbiter number. A value is therefore loaded LSB first. Device d's field is bits [9d+8:9d].
- R4: Device d's code sits in dev_req_ni[2d+1:2d]. Code 0 is a high request and code 1 is a low request. Codes 2 and 3 mean no request. The ranking key is {low, field}, and the smaller key wins.
- R5: When several requesters share the smallest key, the first one found scanning upward from the last granted device (wrapping around) is granted.
- R6: Peer j's code sits in peer_req_i[3j+2:3j]. Code 7 means no request, and a smaller code means higher priority. The local level is the top 3 bits of the winning key: field[8:7] for a high request and 4+field[8:7] for a low request. A grant is issued only if, for every active peer j, the local level is below the peer code, or equals it with arbiter number <= j.
- R7: No new grant is issued while busy_i is high. busy_o is high exactly while a grant is held.
- R8: A granted device keeps its grant, even when a better request arrives, until its code becomes 2 or 3. The grant then clears at the next edge.
- R9: start_no is low for exactly the first cycle of each grant and is high at all other times.
- R10: At most one grant_o bit is high at any time. A grant appears one clock edge after a winning request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Main asynchronous reset, active low |
| arb_stop_i | input | 1 | Arbiter stop, holds off all grants while high |
| cfg_shift_i | input | 1 | Serial configuration shift enable |
| cfg_sel_i | input | 1 | 0: priority register, 1: arbiter number |
| cfg_din_i | input | 1 | Serial configuration data |
| dev_req_ni | input | 16 | Eight 2-bit device request codes |
| peer_req_i | input | 21 | Seven 3-bit peer request codes |
| busy_i | input | 1 | Bus busy, normally looped from busy_o |
| busy_o | output | 1 | High while a local grant is held |
| grant_o | output | 8 | One-hot device grant |
| start_no | output | 1 | Active-low one-cycle new-grant strobe |

## Verification
The bench aims at the peer tie rules. It covers ties won and lost on the arbiter number, a loss by one level, and a reloaded arbiter number that turns a former win into a loss; a design with the wrong comparison direction or a wrong tie rule grants in the wrong cases. It also covers a better request arriving during a held grant, which a design that re-arbitrates every cycle would steal, and round-robin order among equal keys, where a fixed-priority design always repeats the same device. Further cases are grants attempted under the stop input, under an external busy, and with request code 2, which a design that treats any non-3 code as a request would grant.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int unsigned N_DEV   = 8;
  localparam int unsigned PRIO_W  = 9;
  localparam int unsigned N_PEER  = 7;
  localparam int unsigned PEER_W  = 3;
  localparam int unsigned NUM_W   = 4;
  localparam int unsigned REQ_W   = 2;

  typedef enum logic [REQ_W-1:0] {
    REQ_HIGH = 2'd0,
    REQ_LOW  = 2'd1,
    REQ_RSVD = 2'd2,
    REQ_NONE = 2'd3
  } dev_req_e;
endpackage

// File: rtl/arb_cfg_shift.sv
module arb_cfg_shift #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (en_i) q_q <= {din_i, q_q[W-1:1]};
  end

  assign q_o = q_q;
endmodule

// File: rtl/arb_local_select.sv
module arb_local_select #(
  parameter int unsigned N  = 8,
  parameter int unsigned KW = 10,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]    vld_i,
  input  logic [N*KW-1:0] key_i,
  input  logic [IW-1:0]   last_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o,
  output logic [KW-1:0]   key_o
);
  logic [KW-1:0] min_key;
  logic          found;

  always_comb begin
    min_key = '1;
    for (int d = 0; d < int'(N); d++) begin
      if (vld_i[d] && key_i[d*KW +: KW] < min_key) min_key = key_i[d*KW +: KW];
    end
  end

  // scan upward from the device after the last grant
  always_comb begin
    found = 1'b0;
    idx_o = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int c;
      c = (int'(last_i) + k) % int'(N);
      if (!found && vld_i[c] && key_i[c*KW +: KW] == min_key) begin
        found = 1'b1;
        idx_o = IW'(c);
      end
    end
  end

  assign any_o = |vld_i;
  assign key_o = min_key;
endmodule

// File: rtl/arb_peer_cmp.sv
module arb_peer_cmp #(
  parameter int unsigned NP = 7,
  parameter int unsigned PW = 3,
  parameter int unsigned NW = 4
) (
  input  logic [PW-1:0]    level_i,
  input  logic [NW-1:0]    own_num_i,
  input  logic [NP*PW-1:0] peer_i,
  output logic             win_o
);
  always_comb begin
    win_o = 1'b1;
    for (int j = 0; j < int'(NP); j++) begin
      logic [PW-1:0] code;
      code = peer_i[j*PW +: PW];
      if (code != '1) begin
        if (level_i > code) win_o = 1'b0;
        else if (level_i == code && 32'(own_num_i) > 32'(j)) win_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import prio_arb_pkg::*;
#(
  parameter int unsigned NDEV  = N_DEV,
  parameter int unsigned PW    = PRIO_W,
  parameter int unsigned NPEER = N_PEER,
  parameter int unsigned LVW   = PEER_W,
  parameter int unsigned NW    = NUM_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 arb_stop_i,
  input  logic                 cfg_shift_i,
  input  logic                 cfg_sel_i,
  input  logic                 cfg_din_i,
  input  logic [NDEV*2-1:0]    dev_req_ni,
  input  logic [NPEER*LVW-1:0] peer_req_i,
  input  logic                 busy_i,
  output logic                 busy_o,
  output logic [NDEV-1:0]      grant_o,
  output logic                 start_no
);
  localparam int unsigned KW = PW + 1;
  localparam int unsigned IW = $clog2(NDEV);
  localparam int unsigned CW = NDEV * PW;

  logic [CW-1:0]      prio_cfg;
  logic [NW-1:0]      own_num;
  logic [NDEV-1:0]    vld;
  logic [NDEV*KW-1:0] keys;
  logic               any_req, peer_win;
  logic [IW-1:0]      sel_idx, last_q;
  logic [KW-1:0]      sel_key;
  logic [NDEV-1:0]    grant_q;
  logic               start_q;

  arb_cfg_shift #(.W(CW)) u_prio_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cfg_shift_i && !cfg_sel_i),
    .din_i(cfg_din_i), .q_o(prio_cfg)
  );

  arb_cfg_shift #(.W(NW)) u_num_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cfg_shift_i && cfg_sel_i),
    .din_i(cfg_din_i), .q_o(own_num)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    dev_req_e code;
    logic     lo;
    assign code = dev_req_e'(dev_req_ni[2*d +: 2]);
    assign lo   = (code == REQ_LOW);
    assign vld[d] = (code == REQ_HIGH) || lo;
    assign keys[d*KW +: KW] = {lo, prio_cfg[d*PW +: PW]};
  end

  arb_local_select #(.N(NDEV), .KW(KW)) u_sel (
    .vld_i(vld), .key_i(keys), .last_i(last_q),
    .any_o(any_req), .idx_o(sel_idx), .key_o(sel_key)
  );

  arb_peer_cmp #(.NP(NPEER), .PW(LVW), .NW(NW)) u_peer (
    .level_i(sel_key[KW-1 -: LVW]), .own_num_i(own_num),
    .peer_i(peer_req_i), .win_o(peer_win)
  );

  // last_q doubles as current owner while a grant is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      last_q  <= IW'(NDEV - 1);
      start_q <= 1'b0;
    end else if (arb_stop_i) begin
      grant_q <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (|grant_q) begin
        if (!vld[last_q]) grant_q <= '0;
      end else if (!busy_i && any_req && peer_win) begin
        grant_q <= NDEV'(1) << sel_idx;
        last_q  <= sel_idx;
        start_q <= 1'b1;
      end
    end
  end

  assign grant_o  = grant_q;
  assign busy_o   = |grant_q;
  assign start_no = ~start_q;
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int unsigned NDEV = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arb_stop_i,
  input logic              busy_i,
  input logic [NDEV*2-1:0] dev_req_ni,
  input logic [NDEV-1:0]   grant_o,
  input logic              start_no
);
  logic [NDEV-1:0] req_vld;
  always_comb begin
    for (int d = 0; d < int'(NDEV); d++)
      req_vld[d] = (dev_req_ni[2*d +: 2] == 2'd0) || (dev_req_ni[2*d +: 2] == 2'd1);
  end

  assert_onehot_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_stop_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_stop_i |=> grant_o == '0);

  assert_busy_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && grant_o == '0) |=> grant_o == '0);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & req_vld) != '0 && !arb_stop_i) |=> $stable(grant_o));

  assert_start_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_no |=> start_no);

  assert_start_on_new_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_no |-> (grant_o != '0));
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.NDEV(NDEV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arb_stop_i(arb_stop_i), .busy_i(busy_i),
  .dev_req_ni(dev_req_ni), .grant_o(grant_o), .start_no(start_no)
);

// File: tb/prio_bus_arbiter_tb.sv
module prio_bus_arbiter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arb_stop_i = 1'b1;
  logic        cfg_shift_i = 1'b0, cfg_sel_i = 1'b0, cfg_din_i = 1'b0;
  logic [15:0] dev_req_ni = 16'hFFFF;
  logic [20:0] peer_req_i = 21'h1FFFFF;
  logic        ext_busy = 1'b0;
  logic        busy_i, busy_o, start_no;
  logic [7:0]  grant_o;
  int          total = 0, bad = 0;

  always #4 clk_i = ~clk_i;
  assign busy_i = busy_o | ext_busy;

  prio_bus_arbiter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .arb_stop_i(arb_stop_i),
    .cfg_shift_i(cfg_shift_i), .cfg_sel_i(cfg_sel_i), .cfg_din_i(cfg_din_i),
    .dev_req_ni(dev_req_ni), .peer_req_i(peer_req_i), .busy_i(busy_i),
    .busy_o(busy_o), .grant_o(grant_o), .start_no(start_no)
  );

  // {high mask, low mask, peer index (7 = none), peer code, expected grant}
  typedef struct packed {
    logic [7:0] hi; logic [7:0] lo; logic [2:0] pj; logic [2:0] pc; logic [7:0] exp;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{8'h10, 8'h00, 3'd7, 3'd7, 8'h10},  // R4 key 0 alone
    '{8'h09, 8'h00, 3'd7, 3'd7, 8'h01},  // R4 64 beats 256
    '{8'h01, 8'h10, 3'd7, 3'd7, 8'h01},  // R4 low flag loses
    '{8'h08, 8'h20, 3'd7, 3'd7, 8'h08},  // R4
    '{8'h80, 8'h00, 3'd0, 3'd4, 8'h80},  // R6 level 3 < 4
    '{8'h01, 8'h00, 3'd1, 3'd0, 8'h00},  // R6 tie, num 3 > 1
    '{8'h01, 8'h00, 3'd5, 3'd0, 8'h01},  // R6 tie, num 3 <= 5
    '{8'h20, 8'h00, 3'd3, 3'd1, 8'h20},  // R6 tie, num 3 <= 3
    '{8'h20, 8'h00, 3'd2, 3'd1, 8'h00},  // R6 tie lost
    '{8'h00, 8'h08, 3'd6, 3'd5, 8'h00},  // R6 level 6 > 5
    '{8'h00, 8'h08, 3'd6, 3'd6, 8'h08},  // R6 level 6 tie won
    '{8'h10, 8'h00, 3'd6, 3'd1, 8'h10}   // R6 level 0 < 1
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(logic [7:0] hi, logic [7:0] lo, logic [2:0] pj, logic [2:0] pc);
    for (int d = 0; d < 8; d++)
      dev_req_ni[2*d +: 2] = hi[d] ? 2'd0 : (lo[d] ? 2'd1 : 2'd3);
    for (int j = 0; j < 7; j++)
      peer_req_i[3*j +: 3] = (j == int'(pj)) ? pc : 3'd7;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic shift_cfg(logic sel, int w, logic [71:0] v);
    for (int i = 0; i < w; i++) begin
      @(negedge clk_i);
      cfg_sel_i = sel; cfg_din_i = v[i]; cfg_shift_i = 1'b1;
    end
    @(negedge clk_i);
    cfg_shift_i = 1'b0;
  endtask

  initial begin
    cyc(200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [71:0] pr;
    pr = {9'h1FF, 9'h010, 9'h080, 9'h000, 9'h100, 9'h010, 9'h010, 9'h040};
    cyc(3);
    chk("R1 grant in reset", 32'(grant_o), 0);
    chk("R1 start in reset", 32'(start_no), 1);
    chk("R1 busy in reset", 32'(busy_o), 0);
    rst_ni = 1'b1;
    shift_cfg(1'b0, 72, pr);   // R3 priority load
    shift_cfg(1'b1, 4, 72'd3); // R3 arbiter number 3
    set_req(8'h10, 8'h00, 3'd7, 3'd7);
    cyc(3);
    chk("R2 no grant while stopped", 32'(grant_o), 0);
    arb_stop_i = 1'b0;
    cyc(1);
    chk("R2 grant after release", 32'(grant_o), 32'h10);
    chk("R9 start on first cycle", 32'(start_no), 0);
    cyc(1);
    chk("R9 start single cycle", 32'(start_no), 1);
    chk("R7 busy while held", 32'(busy_o), 1);
    arb_stop_i = 1'b1;
    cyc(1);
    chk("R2 stop clears grant", 32'(grant_o), 0);
    set_req(8'h00, 8'h00, 3'd7, 3'd7);
    arb_stop_i = 1'b0;
    cyc(2);

    for (int i = 0; i < NV; i++) begin
      set_req(VT[i].hi, VT[i].lo, VT[i].pj, VT[i].pc);
      cyc(1);
      chk($sformatf("R4/R6/R10 vector %0d grant", i), 32'(grant_o), 32'(VT[i].exp));
      chk($sformatf("R9 vector %0d start", i), 32'(start_no), (VT[i].exp == 0) ? 1 : 0);
      set_req(8'h00, 8'h00, 3'd7, 3'd7);
      cyc(1);
      chk($sformatf("R8 vector %0d release", i), 32'(grant_o), 0);
      cyc(1);
    end

    // R5 round robin among equal keys 1, 2, 6
    set_req(8'h04, 8'h00, 3'd7, 3'd7);
    cyc(1);
    chk("R5 seed grant d2", 32'(grant_o), 32'h04);
    set_req(8'h00, 8'h00, 3'd7, 3'd7);
    cyc(2);
    set_req(8'h46, 8'h00, 3'd7, 3'd7);
    cyc(1);
    chk("R5 after d2 comes d6", 32'(grant_o), 32'h40);
    set_req(8'h06, 8'h00, 3'd7, 3'd7);
    cyc(1);
    chk("R7 gap after release", 32'(grant_o), 0);
    cyc(1);
    chk("R5 after d6 wraps to d1", 32'(grant_o), 32'h02);
    set_req(8'h04, 8'h00, 3'd7, 3'd7);
    cyc(2);
    chk("R5 then d2", 32'(grant_o), 32'h04);
    set_req(8'h00, 8'h00, 3'd7, 3'd7);
    cyc(2);

    // R8 hold against a better request
    set_req(8'h08, 8'h00, 3'd7, 3'd7);
    cyc(1);
    set_req(8'h18, 8'h00, 3'd7, 3'd7);
    cyc(3);
    chk("R8 held against better key", 32'(grant_o), 32'h08);
    chk("R9 no strobe while held", 32'(start_no), 1);
    set_req(8'h10, 8'h00, 3'd7, 3'd7);
    cyc(2);
    chk("R8 next owner after drop", 32'(grant_o), 32'h10);
    set_req(8'h00, 8'h00, 3'd7, 3'd7);
    cyc(2);

    // R7 external busy
    ext_busy = 1'b1;
    set_req(8'h10, 8'h00, 3'd7, 3'd7);
    cyc(3);
    chk("R7 no grant while busy", 32'(grant_o), 0);
    ext_busy = 1'b0;
    cyc(1);
    chk("R7 grant after busy drops", 32'(grant_o), 32'h10);
    set_req(8'h00, 8'h00, 3'd7, 3'd7);
    cyc(2);

    // R4 code 2 is no request
    dev_req_ni[9:8] = 2'd2;
    cyc(2);
    chk("R4 code 2 ignored", 32'(grant_o), 0);
    dev_req_ni = 16'hFFFF;
    cyc(1);

    // R3/R6 arbiter number 7 loses a former tie win
    shift_cfg(1'b1, 4, 72'd7);
    set_req(8'h20, 8'h00, 3'd3, 3'd1);
    cyc(2);
    chk("R6 number 7 loses tie at peer 3", 32'(grant_o), 0);
    set_req(8'h00, 8'h00, 3'd7, 3'd7);
    shift_cfg(1'b1, 4, 72'd3);
    set_req(8'h20, 8'h00, 3'd3, 3'd1);
    cyc(1);
    chk("R3 reloaded number 3 wins tie", 32'(grant_o), 32'h20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule